// File: doc/BRIEF.md
# Memory protection region matcher

This block decides, for every access address presented to it, which protection region owns that address. It then reports the owning region's attribute bits, or it reports a fault. Eight regions are held in registers. Each region has a base address, a power-of-two size, an enable bit, an eight-bit mask that can switch off single eighths of the region, and a set of attribute fields: memory type, cacheable, bufferable, shareable and access permission. When several enabled regions cover an address, the one with the highest index wins. If an eighth of a region is masked off, that region does not claim addresses inside the masked eighth. A lower-priority region that covers the same addresses can then supply the attributes. If no region covers them, the access faults.

Software programs the regions through a narrow write port. Writes go through a window of four word slots: a global control word, a region select, the selected region's base, and the selected region's packed attribute-and-size word. Only the attribute-and-size word accepts byte and halfword writes. Every other slot takes aligned word writes only. A write of the wrong size, a misaligned write or a write to an unmapped offset is refused. A refused write changes no state and raises an error strobe.

Lookups are pipelined through one register stage. The answer to an address presented in one cycle appears in the next cycle.

Top module: `mpu_region_matcher`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_valid, rsp_hit, rsp_fault and wr_err are 0. Reset clears all region settings and the global enable.
- R2: With the global enable at 0, every lookup returns a hit with no fault, region index 0 and all attribute outputs 0.
- R3: A region with size code N covers 2^(N+1) bytes, starting at its base rounded down to that size. Codes below 4 act as code 4 (32 bytes).
- R4: When several enabled regions cover an address, the response carries the region with the highest index.
- R5: For regions of 256 bytes or more, mask bit i removes the i-th eighth of the region, counted from the lowest address (bit 0 lowest, bit 7 highest). A lower-priority covering region then answers.
- R6: With the global enable at 1 and no matching region, the response is a fault with hit 0, region index 0 and all attribute outputs 0.
- R7: For regions of 32, 64 or 128 bytes (codes up to 6), the mask is ignored and the whole region matches.
- R8: The attribute-and-size word at offset 0xC has the following fields: bit 0 enable; bits 5:1 size code; bits 15:8 mask; bits 18:16 type; bit 19 cacheable; bit 20 bufferable; bit 21 shareable; bits 26:24 permission. It accepts byte writes, halfword writes with address bit 0 clear, and word writes with address bits 1:0 clear. Each written byte is taken from its own lane of wr_data.
- R9: The control word (0x0, bit 0 global enable), the select word (0x4, bits 2:0 region index) and the base word (0x8, bits 31:5 base) take only word writes with address bits 1:0 clear.
- R10: A write that breaks the size and alignment rules, uses wr_size 3, or targets an offset of 0x10 or above raises wr_err one cycle later and changes no state. A legal write leaves wr_err low.
- R11: A lookup presented with lk_valid high yields rsp_valid high exactly one cycle later, with its result. With lk_valid low, the next cycle has rsp_valid, rsp_hit and rsp_fault at 0.
- R12: A region whose enable bit is 0 never matches.
- R13: On a match, the winning region's type, cacheable, bufferable, shareable and permission fields appear unchanged on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| wr_data | input | 32 | Write data, each byte in its own lane |
| wr_err | output | 1 | Refused write, one cycle after the strobe |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to check |
| rsp_valid | output | 1 | Result valid, one cycle after lk_valid |
| rsp_hit | output | 1 | A region or the bypass answered |
| rsp_fault | output | 1 | No enabled region matched |
| rsp_region | output | 3 | Index of the winning region |
| rsp_tex | output | 3 | Memory type field of the winner |
| rsp_c | output | 1 | Cacheable bit of the winner |
| rsp_b | output | 1 | Bufferable bit of the winner |
| rsp_s | output | 1 | Shareable bit of the winner |
| rsp_ap | output | 3 | Permission field of the winner |

## Verification
Lookup results and the write error strobe are both due one clock after the input that causes them. A write takes effect on that same edge, so a lookup issued in the following cycle sees the new settings. The bench keeps a behavioural model that takes the inputs at each rising edge. It first computes the lookup answer against the settings as they stood before that edge, then applies any accepted write. At the next falling edge it compares that prediction with the outputs, so every cycle is checked exactly once against the value due in it.

// File: rtl/mpu_match_pkg.sv
package mpu_match_pkg;

    localparam int ADDR_W        = 32;
    localparam int DATA_W        = 32;
    localparam int MASK_W        = 8;
    localparam int SIZE_W        = 5;
    localparam logic [SIZE_W-1:0] MIN_SIZE_CODE = 5'd4;
    localparam logic [SIZE_W-1:0] SUB_MIN_CODE  = 5'd7;
    localparam logic [DATA_W-1:0] ATTR_WMASK    = 32'h073F_FF3F;

    typedef struct packed {
        logic [2:0] ap;
        logic [2:0] tex;
        logic       c;
        logic       b;
        logic       s;
    } attr_t;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [MASK_W-1:0] srd;
        attr_t             attr;
        logic [ADDR_W-1:0] base;
    } region_cfg_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_SEL  = 2'd1,
        SLOT_BASE = 2'd2,
        SLOT_ATTR = 2'd3
    } reg_slot_e;

    function automatic logic [DATA_W-1:0] attr_word(input region_cfg_t r);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = r.en;
        w[5:1]   = r.size;
        w[15:8]  = r.srd;
        w[18:16] = r.attr.tex;
        w[19]    = r.attr.c;
        w[20]    = r.attr.b;
        w[21]    = r.attr.s;
        w[26:24] = r.attr.ap;
        return w;
    endfunction

    function automatic region_cfg_t attr_unpack(input region_cfg_t r, input logic [DATA_W-1:0] w);
        region_cfg_t o;
        o          = r;
        o.en       = w[0];
        o.size     = w[5:1];
        o.srd      = w[15:8];
        o.attr.tex = w[18:16];
        o.attr.c   = w[19];
        o.attr.b   = w[20];
        o.attr.s   = w[21];
        o.attr.ap  = w[26:24];
        return o;
    endfunction

    function automatic logic [3:0] lane_enable(input acc_size_e sz, input logic [1:0] off);
        case (sz)
            SZ_BYTE: return 4'b0001 << off;
            SZ_HALF: return 4'b0011 << off;
            SZ_WORD: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/mpu_reg_port.sv
module mpu_reg_port
    import mpu_match_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int REG_AW      = 8,
    localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    output logic              glob_en,
    output region_cfg_t       cfg_q [NUM_REGIONS]
);

    logic [SEL_W-1:0]  sel_q;
    reg_slot_e         slot;
    acc_size_e         asz;
    logic [1:0]        off;
    logic              mapped;
    logic              acc_ok;
    logic [3:0]        be;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] new_word;

    always_comb begin
        slot   = reg_slot_e'(wr_addr[3:2]);
        off    = wr_addr[1:0];
        asz    = acc_size_e'(wr_size);
        mapped = (wr_addr >> 4) == '0;
        case (asz)
            SZ_WORD: acc_ok = mapped && (off == 2'd0);
            SZ_HALF: acc_ok = mapped && (slot == SLOT_ATTR) && !off[0];
            SZ_BYTE: acc_ok = mapped && (slot == SLOT_ATTR);
            default: acc_ok = 1'b0;
        endcase
        be       = lane_enable(asz, off);
        cur_word = attr_word(cfg_q[sel_q]);
        for (int k = 0; k < 4; k++) begin
            new_word[k*8 +: 8] = be[k] ? wr_data[k*8 +: 8] : cur_word[k*8 +: 8];
        end
        new_word = new_word & ATTR_WMASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err  <= 1'b0;
            glob_en <= 1'b0;
            sel_q   <= '0;
            for (int r = 0; r < NUM_REGIONS; r++) begin
                cfg_q[r] <= '0;
            end
        end else begin
            wr_err <= wr_en && !acc_ok;
            if (wr_en && acc_ok) begin
                case (slot)
                    SLOT_CTRL: glob_en <= wr_data[0];
                    SLOT_SEL:  sel_q   <= wr_data[SEL_W-1:0];
                    SLOT_BASE: cfg_q[sel_q].base <= {wr_data[DATA_W-1:5], 5'b0};
                    default:   cfg_q[sel_q] <= attr_unpack(cfg_q[sel_q], new_word);
                endcase
            end
        end
    end

    // R10
    refused_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !acc_ok) |=> (wr_err && $stable(glob_en) && $stable(sel_q) && $stable(cfg_q[sel_q])));

    // R10
    legal_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_ok) |=> !wr_err);

endmodule

// File: rtl/mpu_region_cmp.sv
module mpu_region_cmp
    import mpu_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);

    logic [SIZE_W-1:0] eff;
    logic [5:0]        nb;
    logic [ADDR_W-1:0] diff;
    logic              in_range;
    logic [2:0]        sub;
    logic              sub_on;

    always_comb begin
        eff      = (cfg.size < MIN_SIZE_CODE) ? MIN_SIZE_CODE : cfg.size;
        nb       = {1'b0, eff} + 6'd1;
        diff     = addr ^ cfg.base;
        in_range = (diff >> nb) == '0;
        sub      = 3'(addr >> (nb - 6'd3));
        sub_on   = eff >= SUB_MIN_CODE;
        match    = cfg.en && in_range && !(sub_on && cfg.srd[sub]);
    end

    // R7
    small_region_mask_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && in_range && (cfg.size < SUB_MIN_CODE)) |-> match);

    // R12
    disabled_region_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !match);

endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel
    import mpu_match_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_REGIONS-1:0] match,
    input  attr_t                  attrs [NUM_REGIONS],
    output logic                   any,
    output logic [IDX_W-1:0]       idx,
    output attr_t                  attr
);

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        attr = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (match[r]) begin
                any  = 1'b1;
                idx  = IDX_W'(r);
                attr = attrs[r];
            end
        end
    end

    // R4
    highest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ((match >> idx) == NUM_REGIONS'(1)));

endmodule

// File: rtl/mpu_region_matcher.sv
module mpu_region_matcher
    import mpu_match_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int REG_AW      = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               wr_addr,
    input  logic [1:0]                      wr_size,
    input  logic [31:0]                     wr_data,
    output logic                            wr_err,
    input  logic                            lk_valid,
    input  logic [31:0]                     lk_addr,
    output logic                            rsp_valid,
    output logic                            rsp_hit,
    output logic                            rsp_fault,
    output logic [$clog2(NUM_REGIONS)-1:0]  rsp_region,
    output logic [2:0]                      rsp_tex,
    output logic                            rsp_c,
    output logic                            rsp_b,
    output logic                            rsp_s,
    output logic [2:0]                      rsp_ap
);

    localparam int IDX_W = $clog2(NUM_REGIONS);

    logic                   glob_en;
    region_cfg_t            cfg_q [NUM_REGIONS];
    attr_t                  attrs [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] match_vec;
    logic                   any;
    logic [IDX_W-1:0]       win_idx;
    attr_t                  win_attr;
    attr_t                  out_attr;

    mpu_reg_port #(.NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .wr_err  (wr_err),
        .glob_en (glob_en),
        .cfg_q   (cfg_q)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        assign attrs[g] = cfg_q[g].attr;
        mpu_region_cmp u_cmp (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg_q[g]),
            .addr  (lk_addr),
            .match (match_vec[g])
        );
    end

    mpu_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .match (match_vec),
        .attrs (attrs),
        .any   (any),
        .idx   (win_idx),
        .attr  (win_attr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_region <= '0;
            out_attr   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (!lk_valid) begin
                rsp_hit    <= 1'b0;
                rsp_fault  <= 1'b0;
                rsp_region <= '0;
                out_attr   <= '0;
            end else if (!glob_en) begin
                rsp_hit    <= 1'b1;
                rsp_fault  <= 1'b0;
                rsp_region <= '0;
                out_attr   <= '0;
            end else begin
                rsp_hit    <= any;
                rsp_fault  <= !any;
                rsp_region <= any ? win_idx : '0;
                out_attr   <= any ? win_attr : '0;
            end
        end
    end

    assign rsp_tex = out_attr.tex;
    assign rsp_c   = out_attr.c;
    assign rsp_b   = out_attr.b;
    assign rsp_s   = out_attr.s;
    assign rsp_ap  = out_attr.ap;

    // R11
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R11
    idle_response_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    // R2
    bypass_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !glob_en) |=> (rsp_hit && !rsp_fault));

    // R6
    fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (!rsp_hit && rsp_region == '0 && out_attr == '0));

    // R6
    no_match_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && glob_en && match_vec == '0) |=> rsp_fault);

endmodule

// File: tb/mpu_region_matcher_bench.sv
`timescale 1ns/1ps
module mpu_region_matcher_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_c, rsp_b, rsp_s;
    logic [2:0]  rsp_region, rsp_tex, rsp_ap;

    always #4 clk = ~clk;

    mpu_region_matcher u_mpu_region_matcher (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_err(wr_err), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_region(rsp_region), .rsp_tex(rsp_tex), .rsp_c(rsp_c), .rsp_b(rsp_b),
        .rsp_s(rsp_s), .rsp_ap(rsp_ap)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural model state
    bit          m_glob;
    int          m_sel;
    logic [31:0] m_base [8];
    logic [31:0] m_aw   [8];

    // expectations for the cycle after the last rising edge
    bit          e_valid, e_hit, e_fault, e_err;
    int          e_region;
    logic [8:0]  e_attr;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    function automatic bit legal(input logic [7:0] a, input logic [1:0] sz);
        if (a >= 8'h10) return 0;
        if (sz == 2'd2) return a[1:0] == 2'b00;
        if (sz == 2'd1) return (a[3:2] == 2'd3) && !a[0];
        if (sz == 2'd0) return a[3:2] == 2'd3;
        return 0;
    endfunction

    task automatic predict(input logic [31:0] a);
        int win;
        win = -1;
        for (int r = 0; r < 8; r++) begin
            if (m_aw[r][0]) begin
                int n;
                longint unsigned sz, lo, ad;
                n  = int'(m_aw[r][5:1]);
                if (n < 4) n = 4;
                sz = 64'd1 << (n + 1);
                lo = {32'd0, m_base[r]} & ~(sz - 1);
                ad = {32'd0, a};
                if (ad >= lo && ad < lo + sz) begin
                    longint unsigned eighth;
                    eighth = (ad - lo) / (sz / 8);
                    if (n < 7 || !m_aw[r][8 + int'(eighth)]) win = r;
                end
            end
        end
        if (!m_glob) begin
            e_hit = 1; e_fault = 0; e_region = 0; e_attr = '0;
        end else if (win < 0) begin
            e_hit = 0; e_fault = 1; e_region = 0; e_attr = '0;
        end else begin
            e_hit = 1; e_fault = 0; e_region = win;
            e_attr = {m_aw[win][26:24], m_aw[win][18:16], m_aw[win][19], m_aw[win][20], m_aw[win][21]};
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_glob = 0; m_sel = 0;
            for (int r = 0; r < 8; r++) begin m_base[r] = '0; m_aw[r] = '0; end
            e_valid = 0; e_hit = 0; e_fault = 0; e_err = 0; e_region = 0; e_attr = '0;
        end else begin
            e_valid = lk_valid;
            if (lk_valid) predict(lk_addr);
            else begin e_hit = 0; e_fault = 0; e_region = 0; e_attr = '0; end
            e_err = wr_en && !legal(wr_addr, wr_size);
            if (wr_en && legal(wr_addr, wr_size)) begin
                case (wr_addr[3:2])
                    2'd0: m_glob = wr_data[0];
                    2'd1: m_sel = int'(wr_data[2:0]);
                    2'd2: m_base[m_sel] = wr_data & 32'hFFFF_FFE0;
                    default: begin
                        for (int k = 0; k < 4; k++) begin
                            bit take;
                            take = (wr_size == 2'd2) ||
                                   (wr_size == 2'd1 && (k == int'(wr_addr[1:0]) || k == int'(wr_addr[1:0]) + 1)) ||
                                   (wr_size == 2'd0 && k == int'(wr_addr[1:0]));
                            if (take) m_aw[m_sel][k*8 +: 8] = wr_data[k*8 +: 8];
                        end
                        m_aw[m_sel] = m_aw[m_sel] & 32'h073F_FF3F;
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check(rsp_valid == e_valid, "valid", 32'(rsp_valid), 32'(e_valid));
            check(wr_err == e_err, "wr_err", 32'(wr_err), 32'(e_err));
            if (e_valid) begin
                check(rsp_hit == e_hit, "hit", 32'(rsp_hit), 32'(e_hit));
                check(rsp_fault == e_fault, "fault", 32'(rsp_fault), 32'(e_fault));
                check(int'(rsp_region) == e_region, "region", 32'(rsp_region), 32'(e_region));
                check({rsp_ap, rsp_tex, rsp_c, rsp_b, rsp_s} == e_attr, "attr",
                      32'({rsp_ap, rsp_tex, rsp_c, rsp_b, rsp_s}), 32'(e_attr));
            end else begin
                check(!rsp_hit && !rsp_fault, "idle", 32'({rsp_hit, rsp_fault}), 32'd0);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic lk(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0;
    endtask

    // region program helper: select, base, attribute word
    task automatic region(input int idx, input logic [31:0] base, input logic [31:0] aw);
        wr(8'h04, 2'd2, 32'(idx));
        wr(8'h08, 2'd2, base);
        wr(8'h0C, 2'd2, aw);
    endtask

    function automatic logic [31:0] aword(input bit en, input int n, input logic [7:0] srd,
                                          input logic [2:0] tex, input bit c, input bit b,
                                          input bit s, input logic [2:0] ap);
        return {5'b0, ap, 2'b0, s, b, c, tex, srd, 2'b0, 5'(n), en};
    endfunction

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        lk(32'h0000_0000);
        lk(32'hFFFF_FFFC);

        cur_req = "R9";
        wr(8'h00, 2'd2, 32'h1);
        cur_req = "R6";
        lk(32'h1234_5678);

        cur_req = "R3";
        region(0, 32'h2000_0000, aword(1, 9, 8'h00, 3'd1, 1, 0, 0, 3'd3));
        lk(32'h2000_0000);
        lk(32'h2000_03FC);
        lk(32'h2000_0400);
        lk(32'h1FFF_FFFC);
        region(1, 32'h3000_0010, aword(1, 2, 8'h00, 3'd2, 0, 1, 1, 3'd1));
        lk(32'h3000_001F);
        lk(32'h3000_0020);

        cur_req = "R4";
        region(2, 32'h2000_0000, aword(1, 8, 8'h00, 3'd4, 0, 0, 1, 3'd6));
        lk(32'h2000_0100);
        lk(32'h2000_0300);

        cur_req = "R5";
        region(3, 32'h4000_0000, aword(1, 16, 8'h00, 3'd0, 1, 0, 0, 3'd2));
        region(4, 32'h4000_0000, aword(1, 18, 8'h03, 3'd5, 1, 1, 1, 3'd7));
        lk(32'h4000_0000);
        lk(32'h4001_FFFF);
        lk(32'h4002_0000);
        cur_req = "R12";
        wr(8'h04, 2'd2, 32'd3);
        wr(8'h0C, 2'd0, 32'h0000_0020);
        lk(32'h4000_0000);
        lk(32'h4002_0000);
        cur_req = "R8";
        wr(8'h04, 2'd2, 32'd4);
        wr(8'h0D, 2'd0, 32'h0000_8000);
        cur_req = "R5";
        lk(32'h4007_0000);
        lk(32'h4006_FFFF);
        lk(32'h4000_0000);

        cur_req = "R7";
        region(5, 32'h5000_0000, aword(1, 6, 8'hFF, 3'd0, 0, 0, 0, 3'd0));
        lk(32'h5000_0000);
        lk(32'h5000_007C);
        lk(32'h5000_0080);

        cur_req = "R8";
        wr(8'h0E, 2'd1, 32'h002D_0000);
        wr(8'h0F, 2'd0, 32'h0500_0000);
        cur_req = "R13";
        lk(32'h5000_0040);

        cur_req = "R10";
        wr(8'h06, 2'd2, 32'hFFFF_FFFF);
        wr(8'h08, 2'd1, 32'h0000_0000);
        wr(8'h00, 2'd0, 32'h0000_0000);
        wr(8'h0C, 2'd3, 32'h0000_0000);
        wr(8'h0D, 2'd1, 32'h0000_0000);
        wr(8'h10, 2'd2, 32'h0000_0000);
        wr(8'h04, 2'd0, 32'h0000_0001);
        lk(32'h5000_0040);
        lk(32'h2000_0100);

        cur_req = "R12";
        region(6, 32'h6000_0000, aword(0, 12, 8'h00, 3'd7, 1, 1, 1, 3'd7));
        lk(32'h6000_0000);

        cur_req = "R11";
        @(negedge clk);
        lk_valid = 1; lk_addr = 32'h2000_0000;
        @(negedge clk); lk_addr = 32'h4002_0000;
        @(negedge clk); lk_addr = 32'h7000_0000;
        @(negedge clk); lk_valid = 0;
        @(negedge clk);

        cur_req = "R2";
        wr(8'h00, 2'd2, 32'h0);
        lk(32'h2000_0000);
        lk(32'h7000_0000);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule